// File: doc/BRIEF.md
# Readout Throttle State Generator

This block decides the flow-control state that a readout concentrator reports upstream. On every bunch-crossing clock it looks at the busy and overflow-warning flags of all front-end input links, the receiver error flag of each link, and the Level-1 accept strobe. From these it drives a 4-bit throttle code that tells the trigger to keep sending, to slow down, or to stop. It also stores a copy of that code at each accept so the copy can travel with the event.

It also runs its own rate rule. It counts accepts over a sliding window of crossings, and more than a set number of accepts inside that window forces the warning state. While a link reports a receiver error, the flags of that link are frozen at their last good values, so corrupted status bits cannot move the output. If a link error lasts too long, the block enters a sticky error state, and only a resync input clears it. Every other state returns to ready as soon as its causes are gone. The link flags feed the next-state logic directly, with no pipeline in front of it, so the response takes one crossing.

Top module: `thr_state_gen`

## Requirements
- R1: A synchronous reset sets both `tts_code` and `evt_tts` to READY (4'b1000) and empties the accept history, so accepts seen before the reset never count toward the rate rule.
- R2: `tts_code` always holds one of four codes: READY=4'b1000, BUSY=4'b0100, OVERFLOW-WARNING=4'b0001, ERROR=4'b1100. When several causes are active at once, ERROR wins over OVERFLOW-WARNING, OVERFLOW-WARNING wins over BUSY, and BUSY wins over READY.
- R3: When any enabled link raises its overflow-warning flag at a crossing, `tts_code` shows OVERFLOW-WARNING after the next clock edge. When any enabled link raises its busy flag at a crossing, `tts_code` shows BUSY after the next clock edge.
- R4: A link whose bit in `link_en` is 0 has no effect at all: its busy, overflow-warning and error flags change neither `tts_code` nor the error state.
- R5: While `link_err` of a link is high, that link counts with the busy and overflow-warning values it had in the last crossing before the error. Changes to those flags during the error have no effect on `tts_code`.
- R6: When an accept brings the number of accepts within the last WINDOW crossings (including the current crossing) above LIMIT, `tts_code` is OVERFLOW-WARNING from the second edge after that accept. Exactly LIMIT accepts in the window do not trigger a warning.
- R7: When the window count falls back to LIMIT, the rate warning stays asserted for one more crossing.
- R8: When an enabled link keeps `link_err` high for more than `err_limit` consecutive crossings, the block enters ERROR. The error state holds after the link error clears, and ends only at the edge where `resync` is sampled high. `tts_code` leaves ERROR one crossing after that edge.
- R9: At each edge where `l1a` is high, `evt_tts` takes the value that `tts_code` shows during that crossing. At all other edges `evt_tts` keeps its value.
- R10: The output never sticks in BUSY or OVERFLOW-WARNING. Once every cause has cleared, `tts_code` returns to READY after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| link_en | input | N_LINKS | Per-link enable mask |
| link_ow | input | N_LINKS | Per-link overflow-warning flags from the input receivers |
| link_busy | input | N_LINKS | Per-link busy flags from the input receivers |
| link_err | input | N_LINKS | Per-link receiver error flags |
| l1a | input | 1 | Level-1 accept strobe, one per accepted crossing |
| resync | input | 1 | Clears the sticky error state |
| err_limit | input | ERR_W | Longest link error duration, in crossings, that is tolerated |
| tts_code | output | 4 | Current throttle code |
| evt_tts | output | 4 | Throttle code captured at the last accept |

## Verification
The assertions assume that reset is held for at least one edge at start-up. They also assume that `err_limit` stays constant while a link error is being timed, and that `resync` is a level taken as sampled at the edge. The bench changes every input only at the falling clock edge. It changes `err_limit` only when no link is in error. It runs rate-rule scenarios only after an idle gap longer than WINDOW, so no earlier accepts are still inside the window when a check is counted.

// File: rtl/thr_pkg.sv
package thr_pkg;
   typedef enum logic [3:0] {
      TTS_READY = 4'b1000,
      TTS_BUSY  = 4'b0100,
      TTS_OVFW  = 4'b0001,
      TTS_ERROR = 4'b1100
   } tts_e;
endpackage

// File: rtl/thr_link_merge.sv
module thr_link_merge #(
   parameter int N_LINKS = 12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINKS-1:0] en,
   input  logic [N_LINKS-1:0] ow,
   input  logic [N_LINKS-1:0] busy,
   input  logic [N_LINKS-1:0] err,
   output logic               any_ow,
   output logic               any_busy
);
   logic [N_LINKS-1:0] held_ow, held_busy;
   logic [N_LINKS-1:0] eff_ow, eff_busy;

   for (genvar i = 0; i < N_LINKS; i++) begin : g_link
      always_ff @(posedge clk) begin
         if (rst) begin
            held_ow[i]   <= 1'b0;
            held_busy[i] <= 1'b0;
         end else if (!err[i]) begin
            held_ow[i]   <= ow[i];
            held_busy[i] <= busy[i];
         end
      end

      assign eff_ow[i]   = en[i] & (err[i] ? held_ow[i]   : ow[i]);
      assign eff_busy[i] = en[i] & (err[i] ? held_busy[i] : busy[i]);

      // R5: consecutive error crossings keep the effective flags frozen
      a_r5_frozen_flags : assert property (@(posedge clk) disable iff (rst)
         (err[i] && en[i]) |=> ((err[i] && en[i]) -> ($stable(eff_ow[i]) && $stable(eff_busy[i]))));
   end

   assign any_ow   = |eff_ow;
   assign any_busy = |eff_busy;
endmodule

// File: rtl/thr_rate_window.sv
module thr_rate_window #(
   parameter int WINDOW = 12000,
   parameter int LIMIT  = 30
) (
   input  logic clk,
   input  logic rst,
   input  logic l1a,
   output logic rate_warn
);
   localparam int DEPTH = LIMIT + 1;
   localparam int TS_W  = $clog2(WINDOW) + 1;
   localparam int PTR_W = $clog2(DEPTH);
   localparam int OCC_W = $clog2(DEPTH + 1);
   localparam logic [TS_W-1:0]  WIN_TS   = TS_W'(WINDOW);
   localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   if (LIMIT < 1)       begin : g_bad_limit  $error("LIMIT must be at least 1"); end
   if (WINDOW <= LIMIT) begin : g_bad_window $error("WINDOW must exceed LIMIT"); end

   logic [TS_W-1:0]  now_q;
   logic [TS_W-1:0]  ts_mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic [OCC_W-1:0] occ;
   logic             hold_q;
   logic [TS_W-1:0]  age;
   logic             expire, full, drop, pop;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_LAST) ? '0 : p + 1'b1;
   endfunction

   always_comb begin
      age    = now_q - ts_mem[rd_ptr];
      expire = (occ != '0) && (age >= WIN_TS);
      full   = (occ == OCC_FULL);
      drop   = l1a && full && !expire;
      pop    = expire || drop;
   end

   always_ff @(posedge clk) begin
      if (l1a) ts_mem[wr_ptr] <= now_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         now_q  <= '0;
         rd_ptr <= '0;
         wr_ptr <= '0;
         occ    <= '0;
         hold_q <= 1'b0;
      end else begin
         now_q  <= now_q + 1'b1;
         if (l1a) wr_ptr <= ptr_inc(wr_ptr);
         if (pop) rd_ptr <= ptr_inc(rd_ptr);
         occ    <= occ - OCC_W'(pop) + OCC_W'(l1a);
         hold_q <= full;
      end
   end

   assign rate_warn = full | hold_q;

   a_r6_occ_bounded : assert property (@(posedge clk) disable iff (rst)
      occ <= OCC_FULL);
   a_r6_full_needs_accept : assert property (@(posedge clk) disable iff (rst)
      (!full && !l1a) |=> !full);
   a_r7_hold_after_full : assert property (@(posedge clk) disable iff (rst)
      full |=> rate_warn);
endmodule

// File: rtl/thr_err_timer.sv
module thr_err_timer #(
   parameter int N_LINKS = 12,
   parameter int ERR_W   = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINKS-1:0] en,
   input  logic [N_LINKS-1:0] err,
   input  logic               resync,
   input  logic [ERR_W-1:0]   err_limit,
   output logic               err_sticky
);
   logic [N_LINKS-1:0] too_long;

   for (genvar i = 0; i < N_LINKS; i++) begin : g_cnt
      logic [ERR_W-1:0] run_q;
      logic             active;
      assign active      = en[i] & err[i];
      assign too_long[i] = active && (run_q >= err_limit);

      always_ff @(posedge clk) begin
         if (rst || resync || !active) run_q <= '0;
         else if (run_q != '1)         run_q <= run_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || resync) err_sticky <= 1'b0;
      else if (|too_long) err_sticky <= 1'b1;
   end

   a_r8_resync_clears : assert property (@(posedge clk) disable iff (rst)
      resync |=> !err_sticky);
   a_r8_sticky_holds : assert property (@(posedge clk) disable iff (rst)
      (err_sticky && !resync) |=> err_sticky);
   a_r4_masked_no_error : assert property (@(posedge clk) disable iff (rst)
      (!err_sticky && (en & err) == '0) |=> !err_sticky);
endmodule

// File: rtl/thr_state_gen.sv
module thr_state_gen
   import thr_pkg::*;
#(
   parameter int N_LINKS = 12,
   parameter int WINDOW  = 12000,
   parameter int LIMIT   = 30,
   parameter int ERR_W   = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINKS-1:0] link_en,
   input  logic [N_LINKS-1:0] link_ow,
   input  logic [N_LINKS-1:0] link_busy,
   input  logic [N_LINKS-1:0] link_err,
   input  logic               l1a,
   input  logic               resync,
   input  logic [ERR_W-1:0]   err_limit,
   output logic [3:0]         tts_code,
   output logic [3:0]         evt_tts
);
   if (N_LINKS < 1) begin : g_bad_links $error("N_LINKS must be at least 1"); end
   if (ERR_W < 1)   begin : g_bad_errw  $error("ERR_W must be at least 1"); end

   logic any_ow, any_busy, rate_warn, err_sticky;
   tts_e code_nxt;

   thr_link_merge #(.N_LINKS(N_LINKS)) u_merge (
      .clk(clk), .rst(rst), .en(link_en), .ow(link_ow), .busy(link_busy),
      .err(link_err), .any_ow(any_ow), .any_busy(any_busy));

   thr_rate_window #(.WINDOW(WINDOW), .LIMIT(LIMIT)) u_rate (
      .clk(clk), .rst(rst), .l1a(l1a), .rate_warn(rate_warn));

   thr_err_timer #(.N_LINKS(N_LINKS), .ERR_W(ERR_W)) u_err (
      .clk(clk), .rst(rst), .en(link_en), .err(link_err), .resync(resync),
      .err_limit(err_limit), .err_sticky(err_sticky));

   always_comb begin
      if (err_sticky)               code_nxt = TTS_ERROR;
      else if (any_ow || rate_warn) code_nxt = TTS_OVFW;
      else if (any_busy)            code_nxt = TTS_BUSY;
      else                          code_nxt = TTS_READY;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tts_code <= TTS_READY;
         evt_tts  <= TTS_READY;
      end else begin
         tts_code <= code_nxt;
         if (l1a) evt_tts <= tts_code;
      end
   end

   a_r2_legal_code : assert property (@(posedge clk) disable iff (rst)
      tts_code inside {TTS_READY, TTS_BUSY, TTS_OVFW, TTS_ERROR});
   a_r8_error_out : assert property (@(posedge clk) disable iff (rst)
      err_sticky |=> tts_code == TTS_ERROR);
   a_r9_evt_stable : assert property (@(posedge clk) disable iff (rst)
      !l1a |=> $stable(evt_tts));
   a_r10_recover : assert property (@(posedge clk) disable iff (rst)
      (!err_sticky && !rate_warn && !any_ow && !any_busy) |=> tts_code == TTS_READY);
endmodule

// File: tb/thr_state_gen_bench.sv
module thr_state_gen_bench;
   localparam int N  = 4;
   localparam int WIN = 20;
   localparam int LIM = 3;
   localparam int EW = 8;
   localparam logic [3:0] RDY = 4'b1000, BSY = 4'b0100, OVW = 4'b0001, ERR = 4'b1100;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0] link_en = '1, link_ow = '0, link_busy = '0, link_err = '0;
   logic l1a = 1'b0, resync = 1'b0;
   logic [EW-1:0] err_limit = 8'd100;
   logic [3:0] tts_code, evt_tts;
   int n_tests = 0, n_fail = 0;

   always #4 clk = ~clk;

   thr_state_gen #(.N_LINKS(N), .WINDOW(WIN), .LIMIT(LIM), .ERR_W(EW)) u_thr_state_gen (
      .clk(clk), .rst(rst), .link_en(link_en), .link_ow(link_ow), .link_busy(link_busy),
      .link_err(link_err), .l1a(l1a), .resync(resync), .err_limit(err_limit),
      .tts_code(tts_code), .evt_tts(evt_tts));

   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic t_reset;
      check("R1 reset tts", tts_code, RDY);
      check("R1 reset evt", evt_tts, RDY);
      l1a = 1'b1; tick(3); l1a = 1'b0;
      rst = 1'b1; tick(); rst = 1'b0;
      check("R1 tts after mid reset", tts_code, RDY);
      l1a = 1'b1; tick(); l1a = 1'b0; tick(2);
      check("R1 history cleared", tts_code, RDY);
   endtask

   task automatic t_link_flags;
      link_busy[0] = 1'b1; tick();
      check("R3 busy", tts_code, BSY);
      link_ow[1] = 1'b1; tick();
      check("R2 ow beats busy", tts_code, OVW);
      link_ow[1] = 1'b0; tick();
      check("R3 back to busy", tts_code, BSY);
      link_busy[0] = 1'b0; tick();
      check("R10 recover ready", tts_code, RDY);
   endtask

   task automatic t_capture;
      link_busy[1] = 1'b1; tick();
      l1a = 1'b1; tick();
      check("R9 capture busy", evt_tts, BSY);
      l1a = 1'b0; link_busy[1] = 1'b0; tick();
      check("R9 no accept keeps", evt_tts, BSY);
      check("R10 ready after busy", tts_code, RDY);
      l1a = 1'b1; tick(); l1a = 1'b0;
      check("R9 capture ready", evt_tts, RDY);
      tick(WIN + 5);
   endtask

   task automatic t_rate;
      l1a = 1'b1; tick(LIM); l1a = 1'b0; tick();
      check("R6 at limit no warn", tts_code, RDY);
      tick(WIN + 5);
      l1a = 1'b1; tick(LIM + 1); l1a = 1'b0;
      check("R6 not yet", tts_code, RDY);
      tick();
      check("R6 over limit", tts_code, OVW);
      tick(17);
      check("R7 hold crossing", tts_code, OVW);
      tick();
      check("R10 rate recovers", tts_code, RDY);
      tick(WIN + 5);
   endtask

   task automatic t_freeze;
      err_limit = 8'd100;
      link_ow[2] = 1'b1; tick();
      check("R3 ow", tts_code, OVW);
      link_err[2] = 1'b1; link_ow[2] = 1'b0; tick(3);
      check("R5 held ow", tts_code, OVW);
      link_err[2] = 1'b0; tick();
      check("R10 ready after err", tts_code, RDY);
      link_err[2] = 1'b1; tick(); link_ow[2] = 1'b1; tick(2);
      check("R5 rise ignored", tts_code, RDY);
      link_err[2] = 1'b0; tick();
      check("R5 live after err", tts_code, OVW);
      link_ow[2] = 1'b0; tick();
      check("R10 ready", tts_code, RDY);
   endtask

   task automatic t_error;
      err_limit = 8'd5;
      link_err[3] = 1'b1; tick(5); link_err[3] = 1'b0; tick();
      check("R8 at limit no error", tts_code, RDY);
      link_err[3] = 1'b1; tick(6); link_err[3] = 1'b0;
      check("R8 not yet", tts_code, RDY);
      tick();
      check("R8 error", tts_code, ERR);
      link_ow[0] = 1'b1; tick(3);
      check("R2 error beats ow", tts_code, ERR);
      resync = 1'b1; tick(); resync = 1'b0;
      check("R8 one crossing lag", tts_code, ERR);
      tick();
      check("R8 resync clears", tts_code, OVW);
      link_ow[0] = 1'b0; tick();
      check("R10 ready", tts_code, RDY);
      err_limit = 8'd100;
   endtask

   task automatic t_mask;
      err_limit = 8'd2;
      link_en[1] = 1'b0;
      link_busy[1] = 1'b1; tick(2);
      check("R4 masked busy", tts_code, RDY);
      link_ow[1] = 1'b1; link_err[1] = 1'b1; tick(10);
      check("R4 masked ow err", tts_code, RDY);
      link_err[1] = 1'b0; link_ow[1] = 1'b0; link_busy[1] = 1'b0; tick();
      link_en[1] = 1'b1; tick();
      check("R4 masked no error left", tts_code, RDY);
      err_limit = 8'd100;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      rst = 1'b0;
      tick();
      t_reset();
      t_link_flags();
      t_capture();
      t_rate();
      t_freeze();
      t_error();
      t_mask();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule